// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a four-bit counter with two independent count strobes: a rising edge on the up strobe advances the count, and a rising edge on the down strobe steps it back. A parameter fixes the counting sequence at build time. In binary mode the counter runs modulo 16. In decade mode it runs in 8421 BCD from 0 to 9. A single system clock samples both strobes, and a strobe only counts on the clock where a low-to-high change is first seen.

An active-low load input copies a preset bus onto the count, and an active-high clear forces the count to zero. Both act on the output at once, without waiting for a clock edge. Clear takes precedence over load, and both take precedence over the strobes. Two active-low terminal-count outputs make chaining possible. Wire a stage's carry output to the next stage's up strobe and its borrow output to the next stage's down strobe, and multi-digit counters need no glue logic. On each stage, the strobe that is not in use is held high.

Top module: `updown_counter4`

## Requirements
- R1: While clear and load are inactive, the count moves by exactly one, up or down, only on a system clock where exactly one strobe shows a low-to-high change. The new value appears at the output one clock after that edge is sampled.
- R2: In binary mode, counting up from 15 gives 0 and counting down from 0 gives 15.
- R3: In decade mode, counting up from 9 gives 0, counting down from 0 gives 9, and counting never leaves the range 0 to 9 once it is inside it.
- R4: In decade mode, a preset of 10 to 15 is loaded unchanged. From such a value, an up edge gives 0 and produces no carry, and a down edge gives the value minus one.
- R5: While load (active low) is asserted, the count output equals the preset bus in the same cycle, with no clock needed, and strobe edges have no effect. After load is released the preset value is held.
- R6: While clear (active high) is asserted, the count output is 0 in the same cycle, whatever load, the preset bus or the strobes are doing. After clear is released, 0 is held.
- R7: The carry output (active low) is 0 only when the count equals the mode maximum (15 binary, 9 decade) and the up strobe is low. It rises together with the up-strobe edge that wraps the stage.
- R8: The borrow output (active low) is 0 only when the count is 0 and the down strobe is low. It rises together with the down-strobe edge that wraps the stage.
- R9: Rising edges on both strobes in the same system clock leave the count unchanged. A strobe held low or held high for any number of clocks produces no count.
- R10: Two stages chained through carry and borrow, with the idle strobe held high, count 0 to 255 in binary and 0 to 99 in decade. They wrap in both directions.
- R11: The synchronous reset sets the count to 0 and treats both strobes as previously high, so a strobe that is already high at reset release does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Master clear, active high, immediate |
| ld_n | input | 1 | Parallel load, active low, immediate |
| preset | input | WIDTH | Value taken while loading |
| up_strobe | input | 1 | Count-up strobe, counts on its rising edge |
| dn_strobe | input | 1 | Count-down strobe, counts on its rising edge |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |

## Verification
The bound checker watches every clock for the following: single steps in either direction, wrap-around at both ends in the selected mode, no change when no edge or clashing edges are seen, the value held after clear or load is released, and terminal outputs that never assert unless their own strobe is low at the matching count. Some behaviour only the bench's scenarios can show. These are: clear and load acting before any clock edge, strobe edges ignored during load, terminal outputs switching in step with the strobe edge, reset release with strobes high, and whole chained sequences through 0 to 255 and 0 to 99 in both directions.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Counting sequence chosen at build time
  typedef enum logic {
    CNT_BINARY = 1'b0,
    CNT_DECADE = 1'b1
  } cnt_mode_e;

  // Action taken by the count register on a given clock
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

endpackage

// File: rtl/updn_edge.sv
// Rising-edge detection for a group of level inputs sampled by clk.
// The remembered level is reset high so a line already high at release
// is not taken as an edge.
module updn_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) lvl_q[i] <= 1'b1;
      else     lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end

endmodule

// File: rtl/updn_next.sv
// Next-count computation; the wrap rule depends on the counting mode.
module updn_next
  import updn_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter cnt_mode_e MODE  = CNT_BINARY,
  parameter logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}}
) (
  input  logic [WIDTH-1:0] cur,
  input  step_e            step,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  if (MODE == CNT_DECADE) begin : g_decade
    // Any value at or above the top returns to zero when counting up
    always_comb begin
      unique case (step)
        STEP_INC: nxt = (cur >= MAXV) ? ZERO : cur + ONE;
        STEP_DEC: nxt = (cur == ZERO) ? MAXV : cur - ONE;
        default:  nxt = cur;
      endcase
    end
  end else begin : g_binary
    // Natural modulo-2^WIDTH wrap
    always_comb begin
      unique case (step)
        STEP_INC: nxt = cur + ONE;
        STEP_DEC: nxt = cur - ONE;
        default:  nxt = cur;
      endcase
    end
  end

endmodule

// File: rtl/updn_term.sv
// Terminal-count outputs, gated by the live strobe level so that they can
// drive the next stage's strobes directly.
module updn_term #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}}
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);

  logic at_top;
  logic at_zero;

  assign at_top   = (cnt == MAXV);
  assign at_zero  = (cnt == '0);
  assign carry_n  = ~(at_top  & ~up_lvl);
  assign borrow_n = ~(at_zero & ~dn_lvl);

endmodule

// File: rtl/updown_counter4.sv
module updown_counter4
  import updn_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter cnt_mode_e MODE  = CNT_BINARY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_strobe,
  input  logic             dn_strobe,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [WIDTH-1:0] MAXV =
    (MODE == CNT_DECADE) ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam int NSTRB = 2;
  localparam int UP_IX = 0;
  localparam int DN_IX = 1;

  logic [NSTRB-1:0] strb_lvl;
  logic [NSTRB-1:0] strb_rise;
  step_e            step;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;

  assign strb_lvl[UP_IX] = up_strobe;
  assign strb_lvl[DN_IX] = dn_strobe;

  updn_edge #(.N(NSTRB)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (strb_lvl),
    .rise (strb_rise)
  );

  // Clashing edges cancel
  always_comb begin
    unique case ({strb_rise[DN_IX], strb_rise[UP_IX]})
      2'b01:   step = STEP_INC;
      2'b10:   step = STEP_DEC;
      default: step = STEP_HOLD;
    endcase
  end

  updn_next #(.WIDTH(WIDTH), .MODE(MODE), .MAXV(MAXV)) u_next (
    .cur  (cnt_q),
    .step (step),
    .nxt  (cnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (!ld_n)             cnt_q <= preset;
    else if (step != STEP_HOLD) cnt_q <= cnt_nxt;
  end

  // Clear and load act on the output without waiting for a clock
  always_comb begin
    if (clr)        count = '0;
    else if (!ld_n) count = preset;
    else            count = cnt_q;
  end

  updn_term #(.WIDTH(WIDTH), .MAXV(MAXV)) u_term (
    .cnt      (count),
    .up_lvl   (up_strobe),
    .dn_lvl   (dn_strobe),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

endmodule

// File: rtl/updown_counter4_chk.sv
module updown_counter4_chk
  import updn_pkg::*;
#(
  parameter int        WIDTH = 4,
  parameter cnt_mode_e MODE  = CNT_BINARY
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             ld_n,
  input logic [WIDTH-1:0] preset,
  input logic             up_strobe,
  input logic             dn_strobe,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n
);

  localparam logic [WIDTH-1:0] TOP =
    (MODE == CNT_DECADE) ? WIDTH'(9) : {WIDTH{1'b1}};

  logic up_seen, dn_seen;
  logic up_e, dn_e, quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_seen <= 1'b1;
      dn_seen <= 1'b1;
    end else begin
      up_seen <= up_strobe;
      dn_seen <= dn_strobe;
    end
  end

  assign up_e  = up_strobe & ~up_seen;
  assign dn_e  = dn_strobe & ~dn_seen;
  assign quiet = ~clr & ld_n;

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    quiet && !up_e && !dn_e |=> (!quiet || $stable(count)));

  // R9
  clash_chk: assert property (@(posedge clk) disable iff (rst)
    quiet && up_e && dn_e |=> (!quiet || $stable(count)));

  // R1
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    quiet && up_e && !dn_e && (count < TOP)
    |=> (!quiet || (count == $past(count) + 1'b1)));

  // R1
  step_dn_chk: assert property (@(posedge clk) disable iff (rst)
    quiet && dn_e && !up_e && (count != '0)
    |=> (!quiet || (count == $past(count) - 1'b1)));

  // R2
  wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    quiet && up_e && !dn_e && (count >= TOP) |=> (!quiet || (count == '0)));

  // R3
  wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
    quiet && dn_e && !up_e && (count == '0) |=> (!quiet || (count == TOP)));

  // R3
  in_range_chk: assert property (@(posedge clk) disable iff (rst)
    quiet && (count <= TOP) |=> (!quiet || (count <= TOP)));

  // R6
  clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clr) && ld_n |-> (count == '0));

  // R5
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ld_n) && !clr && !$past(clr) |-> (count == $past(preset)));

  // R7
  carry_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (!up_strobe && (count == TOP)));

  // R8
  borrow_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (!dn_strobe && (count == '0)));

endmodule

bind updown_counter4 updown_counter4_chk #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .ld_n      (ld_n),
  .preset    (preset),
  .up_strobe (up_strobe),
  .dn_strobe (dn_strobe),
  .count     (count),
  .carry_n   (carry_n),
  .borrow_n  (borrow_n)
);

// File: tb/updown_counter4_bench.sv
module updown_counter4_bench;
  import updn_pkg::*;

  localparam int W = 4;
  localparam logic [1:0] OP_CLR = 2'd0;
  localparam logic [1:0] OP_LD  = 2'd1;
  localparam logic [1:0] OP_UP  = 2'd2;
  localparam logic [1:0] OP_DN  = 2'd3;
  localparam int NVEC = 14;
  // {op, data, expected binary low stage, expected decade low stage}
  localparam logic [13:0] VEC [NVEC] = '{
    {OP_LD,  4'd7,  4'd7,  4'd7 },
    {OP_UP,  4'd0,  4'd8,  4'd8 },
    {OP_UP,  4'd0,  4'd9,  4'd9 },
    {OP_UP,  4'd0,  4'd10, 4'd0 },
    {OP_DN,  4'd0,  4'd9,  4'd9 },
    {OP_LD,  4'd15, 4'd15, 4'd15},
    {OP_UP,  4'd0,  4'd0,  4'd0 },
    {OP_DN,  4'd0,  4'd15, 4'd9 },
    {OP_LD,  4'd12, 4'd12, 4'd12},
    {OP_DN,  4'd0,  4'd11, 4'd11},
    {OP_CLR, 4'd0,  4'd0,  4'd0 },
    {OP_DN,  4'd0,  4'd15, 4'd9 },
    {OP_LD,  4'd0,  4'd0,  4'd0 },
    {OP_UP,  4'd0,  4'd1,  4'd1 }
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic ld_n = 1'b1;
  logic up = 1'b1;
  logic dn = 1'b1;
  logic [W-1:0] preset_lo = '0;
  logic [W-1:0] preset_hi = '0;

  logic [W-1:0] bin_lo, bin_hi, dec_lo, dec_hi;
  logic bin_c0, bin_b0, bin_c1, bin_b1;
  logic dec_c0, dec_b0, dec_c1, dec_b1;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updown_counter4 #(.WIDTH(W), .MODE(CNT_BINARY)) u_updown_counter4 (
    .clk(clk), .rst(rst), .clr(clr), .ld_n(ld_n), .preset(preset_lo),
    .up_strobe(up), .dn_strobe(dn),
    .count(bin_lo), .carry_n(bin_c0), .borrow_n(bin_b0));

  updown_counter4 #(.WIDTH(W), .MODE(CNT_BINARY)) u_updown_counter4_hi (
    .clk(clk), .rst(rst), .clr(clr), .ld_n(ld_n), .preset(preset_hi),
    .up_strobe(bin_c0), .dn_strobe(bin_b0),
    .count(bin_hi), .carry_n(bin_c1), .borrow_n(bin_b1));

  updown_counter4 #(.WIDTH(W), .MODE(CNT_DECADE)) u_updown_counter4_dlo (
    .clk(clk), .rst(rst), .clr(clr), .ld_n(ld_n), .preset(preset_lo),
    .up_strobe(up), .dn_strobe(dn),
    .count(dec_lo), .carry_n(dec_c0), .borrow_n(dec_b0));

  updown_counter4 #(.WIDTH(W), .MODE(CNT_DECADE)) u_updown_counter4_dhi (
    .clk(clk), .rst(rst), .clr(clr), .ld_n(ld_n), .preset(preset_hi),
    .up_strobe(dec_c0), .dn_strobe(dec_b0),
    .count(dec_hi), .carry_n(dec_c1), .borrow_n(dec_b1));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_up();
    @(negedge clk) up = 1'b0;
    @(negedge clk) up = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_dn();
    @(negedge clk) dn = 1'b0;
    @(negedge clk) dn = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] lo, input logic [W-1:0] hi);
    @(negedge clk);
    ld_n = 1'b0;
    preset_lo = lo;
    preset_hi = hi;
    @(negedge clk) ld_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int vb, vd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R11 reset state, strobes high at release
    chk("R11 bin_lo after reset", bin_lo, 0);
    chk("R11 bin_hi after reset", bin_hi, 0);
    chk("R11 dec_lo after reset", dec_lo, 0);
    chk("R11 carry after reset", bin_c0, 1);
    chk("R11 borrow after reset", bin_b0, 1);
    repeat (4) @(negedge clk);
    chk("R11 no count from high strobes", dec_lo, 0);

    // Table of single-stage steps: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      logic [3:0] d, eb, ed;
      {op, d, eb, ed} = VEC[i];
      case (op)
        OP_CLR: do_clear();
        OP_LD:  do_load(d, 4'd0);
        OP_UP:  pulse_up();
        default: pulse_dn();
      endcase
      chk($sformatf("R1 R2 vec%0d binary", i), bin_lo, eb);
      chk($sformatf("R3 R4 vec%0d decade", i), dec_lo, ed);
    end

    // R5 load is immediate and masks strobe edges
    @(negedge clk);
    ld_n = 1'b0;
    preset_lo = 4'd6;
    preset_hi = 4'd0;
    #2 chk("R5 load before clock", bin_lo, 6);
    pulse_up();
    chk("R5 edge ignored during load", bin_lo, 6);
    @(negedge clk) ld_n = 1'b1;
    @(negedge clk);
    chk("R5 value held after load", bin_lo, 6);

    // R6 clear is immediate and beats load
    @(negedge clk);
    ld_n = 1'b0;
    preset_lo = 4'd5;
    clr = 1'b1;
    #2 chk("R6 clear over load binary", bin_lo, 0);
    chk("R6 clear over load decade", dec_lo, 0);
    @(negedge clk);
    clr = 1'b0;
    ld_n = 1'b1;
    @(negedge clk);
    chk("R6 zero held after clear", bin_lo, 0);

    // R9 clashing edges and held strobes
    do_load(4'd3, 4'd0);
    @(negedge clk);
    up = 1'b0;
    dn = 1'b0;
    @(negedge clk);
    up = 1'b1;
    dn = 1'b1;
    @(negedge clk);
    chk("R9 clashing edges", bin_lo, 3);
    @(negedge clk) up = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 strobe held low", bin_lo, 3);
    up = 1'b1;
    @(negedge clk);
    chk("R1 single edge after hold", bin_lo, 4);
    repeat (5) @(negedge clk);
    chk("R9 strobe held high", bin_lo, 4);

    // R7 carry gating and alignment
    do_load(4'd15, 4'd0);
    @(negedge clk) up = 1'b0;
    #2 chk("R7 binary carry at 15", bin_c0, 0);
    chk("R7 decade no carry at 15", dec_c0, 1);
    @(negedge clk) up = 1'b1;
    #2 chk("R7 carry rises with strobe", bin_c0, 1);
    @(negedge clk);
    chk("R10 binary carry advances upper", bin_hi, 1);
    chk("R4 decade 15 up gives 0", dec_lo, 0);
    chk("R4 decade 15 up no carry", dec_hi, 0);
    do_load(4'd9, 4'd0);
    @(negedge clk) up = 1'b0;
    #2 chk("R7 decade carry at 9", dec_c0, 0);
    chk("R7 binary no carry at 9", bin_c0, 1);
    @(negedge clk) up = 1'b1;
    @(negedge clk);
    chk("R3 decade 9 up gives 0", dec_lo, 0);
    chk("R10 decade carry advances upper", dec_hi, 1);

    // R8 borrow gating
    do_clear();
    @(negedge clk) dn = 1'b0;
    #2 chk("R8 binary borrow at 0", bin_b0, 0);
    chk("R8 decade borrow at 0", dec_b0, 0);
    @(negedge clk) dn = 1'b1;
    @(negedge clk);
    chk("R8 binary borrow wraps pair", bin_hi * 16 + bin_lo, 255);
    chk("R8 decade borrow wraps pair", dec_hi * 10 + dec_lo, 99);
    do_load(4'd1, 4'd0);
    @(negedge clk) dn = 1'b0;
    #2 chk("R8 no borrow at 1", bin_b0, 1);
    @(negedge clk) dn = 1'b1;
    @(negedge clk);
    chk("R8 upper untouched", bin_hi, 0);

    // R10 chained counting both directions
    do_clear();
    vb = 0;
    vd = 0;
    for (int k = 0; k < 256; k++) begin
      pulse_up();
      vb = (vb + 1) % 256;
      vd = (vd + 1) % 100;
      chk("R10 binary chain up", bin_hi * 16 + bin_lo, vb);
      chk("R10 decade chain up", dec_hi * 10 + dec_lo, vd);
    end
    for (int k = 0; k < 256; k++) begin
      pulse_dn();
      vb = (vb + 255) % 256;
      vd = (vd + 99) % 100;
      chk("R10 binary chain down", bin_hi * 16 + bin_lo, vb);
      chk("R10 decade chain down", dec_hi * 10 + dec_lo, vd);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule